// File: doc/BRIEF.md
# Unrolled MD5 Candidate Search Core

This core runs an exhaustive search for a message whose MD5 digest equals a loaded target. An internal counter produces one candidate per clock. Each candidate is a short, fixed-length string of `CAND_BYTES` bytes taken straight from the counter value. It is formatted into a single padded 512-bit block and sent into a pipeline in which every one of the 64 compression steps is its own registered stage.

After the pipeline has filled, one digest leaves the output stage on every clock. The four initial chaining values are added to it, and it is compared against the target. When a digest matches, the core latches the candidate that produced it and raises a sticky found flag.

A host uses the core in four steps. It writes the target as four 32-bit words. It pulses `start` with a first counter value. It waits for `found`. It may pulse `stop` to halt candidate generation at any time.

Top module: `md5SearchCore`

## Requirements
- R1: Each candidate block holds the counter bytes in these positions. Message byte n, for n < CAND_BYTES, is counter bits [8n+7:8n], and byte n sits in bits [8(n%4)+7:8(n%4)] of word n/4. Byte CAND_BYTES is 0x80. Word 14 equals 8*CAND_BYTES. Every other byte and word is zero.
- R2: `digestOut` is the MD5 compression of that block plus the standard initial chaining values. Digest byte k sits at bits [8k+7:8k], so bits [31:0] hold the final A word.
- R3: While running, successive valid digests belong to successive counter values, one per clock. The counter wraps from all ones to zero.
- R4: The digest of the first candidate (`startValue`) is valid after the 65th rising edge following the edge that samples `start`.
- R5: A write with `targetWe` high stores `targetData` into target bits [32i+31:32i], where i is `targetIdx`. The target resets to zero.
- R6: `found` rises one clock after a valid digest equal to the target appears. `foundCandidate` then holds that digest's candidate. Both then hold until the next `start`, and later matches do not change them.
- R7: On the edge that samples `start`, the core loads the counter and clears `found`. It also invalidates every digest in flight, so `digestValid` stays low until the new first digest arrives. `start` overrides `stop`.
- R8: `stop` freezes the counter and injects no further candidates. Candidates already in flight still emerge, and after that `digestValid` stays low.
- R9: During and straight after reset, `digestValid` and `found` are low and the core is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load counter, flush pipeline, clear found, begin running |
| stop | input | 1 | Freeze counter and stop injecting |
| startValue | input | 8*CAND_BYTES | First candidate loaded by start |
| targetWe | input | 1 | Target word write strobe |
| targetIdx | input | 2 | Target word index |
| targetData | input | 32 | Target word data |
| digestValid | output | 1 | Output digest is valid this cycle |
| digestOut | output | 128 | Digest with chaining values added |
| digestCand | output | 8*CAND_BYTES | Candidate that produced digestOut |
| found | output | 1 | Sticky match flag |
| foundCandidate | output | 8*CAND_BYTES | Candidate of the first match |

## Verification
The bench builds the core with `CAND_BYTES` = 3, which gives a 24-bit counter. With this width the counter wrap is reached by loading a start value just below the top. The pad byte also lands in word 0, inside the same word as the candidate bytes, which tests the formatting boundary. A three-byte candidate also lets the ASCII string "abc" be searched for, so both the bench model and the core are anchored to a well-known published digest.

// File: rtl/md5SearchPkg.sv
package md5SearchPkg;

  typedef struct packed {
    logic flush;
    logic inject;
  } md5Strobe_t;

  typedef struct packed {
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] c;
    logic [31:0] d;
  } md5State_t;

  localparam logic [31:0] IV_A = 32'h67452301;
  localparam logic [31:0] IV_B = 32'hefcdab89;
  localparam logic [31:0] IV_C = 32'h98badcfe;
  localparam logic [31:0] IV_D = 32'h10325476;
  localparam int NUM_STEPS = 64;

  function automatic logic [31:0] stepConst(input int i);
    case (i)
      0: return 32'hd76aa478;  1: return 32'he8c7b756;  2: return 32'h242070db;  3: return 32'hc1bdceee;
      4: return 32'hf57c0faf;  5: return 32'h4787c62a;  6: return 32'ha8304613;  7: return 32'hfd469501;
      8: return 32'h698098d8;  9: return 32'h8b44f7af; 10: return 32'hffff5bb1; 11: return 32'h895cd7be;
      12: return 32'h6b901122; 13: return 32'hfd987193; 14: return 32'ha679438e; 15: return 32'h49b40821;
      16: return 32'hf61e2562; 17: return 32'hc040b340; 18: return 32'h265e5a51; 19: return 32'he9b6c7aa;
      20: return 32'hd62f105d; 21: return 32'h02441453; 22: return 32'hd8a1e681; 23: return 32'he7d3fbc8;
      24: return 32'h21e1cde6; 25: return 32'hc33707d6; 26: return 32'hf4d50d87; 27: return 32'h455a14ed;
      28: return 32'ha9e3e905; 29: return 32'hfcefa3f8; 30: return 32'h676f02d9; 31: return 32'h8d2a4c8a;
      32: return 32'hfffa3942; 33: return 32'h8771f681; 34: return 32'h6d9d6122; 35: return 32'hfde5380c;
      36: return 32'ha4beea44; 37: return 32'h4bdecfa9; 38: return 32'hf6bb4b60; 39: return 32'hbebfbc70;
      40: return 32'h289b7ec6; 41: return 32'heaa127fa; 42: return 32'hd4ef3085; 43: return 32'h04881d05;
      44: return 32'hd9d4d039; 45: return 32'he6db99e5; 46: return 32'h1fa27cf8; 47: return 32'hc4ac5665;
      48: return 32'hf4292244; 49: return 32'h432aff97; 50: return 32'hab9423a7; 51: return 32'hfc93a039;
      52: return 32'h655b59c3; 53: return 32'h8f0ccc92; 54: return 32'hffeff47d; 55: return 32'h85845dd1;
      56: return 32'h6fa87e4f; 57: return 32'hfe2ce6e0; 58: return 32'ha3014314; 59: return 32'h4e0811a1;
      60: return 32'hf7537e82; 61: return 32'hbd3af235; 62: return 32'h2ad7d2bb; 63: return 32'heb86d391;
      default: return 32'h0;
    endcase
  endfunction

  function automatic int stepShift(input int i);
    case ((i / 16) * 4 + (i % 4))
      0: return 7;   1: return 12;  2: return 17;  3: return 22;
      4: return 5;   5: return 9;   6: return 14;  7: return 20;
      8: return 4;   9: return 11; 10: return 16; 11: return 23;
      12: return 6; 13: return 10; 14: return 15;
      default: return 21;
    endcase
  endfunction

  function automatic int stepWord(input int i);
    case (i / 16)
      0: return i % 16;
      1: return (5 * i + 1) % 16;
      2: return (3 * i + 5) % 16;
      default: return (7 * i) % 16;
    endcase
  endfunction

  function automatic logic [31:0] rotl(input logic [31:0] x, input int s);
    return (x << s) | (x >> (32 - s));
  endfunction

endpackage

// File: rtl/md5Step.sv
module md5Step
  import md5SearchPkg::*;
#(
  parameter int STEP = 0,
  parameter int CAND_BYTES = 4,
  localparam int CAND_BITS = 8 * CAND_BYTES
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 flush,
  input  logic                 inValid,
  input  md5State_t            inState,
  input  logic [CAND_BITS-1:0] inCand,
  output logic                 outValid,
  output md5State_t            outState,
  output logic [CAND_BITS-1:0] outCand
);
  localparam int PHASE = STEP / 16;
  localparam logic [31:0] KC = stepConst(STEP);
  localparam int SH = stepShift(STEP);
  localparam int WIDX = stepWord(STEP);

  // Only the counter travels; constant words of the block are rebuilt here as wires.
  function automatic logic [31:0] msgWord(input logic [CAND_BITS-1:0] cand, input int w);
    logic [31:0] word;
    word = '0;
    for (int b = 0; b < 4; b++) begin
      int n;
      n = 4 * w + b;
      if (n < CAND_BYTES) word[8*b +: 8] = 8'(cand >> (8 * n));
      else if (n == CAND_BYTES) word[8*b +: 8] = 8'h80;
    end
    if (w == 14) word = 32'(CAND_BYTES * 8);
    if (w == 15) word = '0;
    return word;
  endfunction

  logic [31:0] mix;
  logic [31:0] msg;
  logic [31:0] sum;
  logic [31:0] newB;

  if (PHASE == 0) begin : gMixF
    assign mix = (inState.b & inState.c) | (~inState.b & inState.d);
  end else if (PHASE == 1) begin : gMixG
    assign mix = (inState.d & inState.b) | (~inState.d & inState.c);
  end else if (PHASE == 2) begin : gMixH
    assign mix = inState.b ^ inState.c ^ inState.d;
  end else begin : gMixI
    assign mix = inState.c ^ (inState.b | ~inState.d);
  end

  assign msg  = msgWord(inCand, WIDX);
  assign sum  = inState.a + mix + KC + msg;
  assign newB = inState.b + rotl(sum, SH);

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid & ~flush;
  end

  always_ff @(posedge clk) begin
    outState <= '{a: inState.d, b: newB, c: inState.b, d: inState.c};
    outCand  <= inCand;
  end
endmodule

// File: rtl/md5Datapath.sv
module md5Datapath
  import md5SearchPkg::*;
#(
  parameter int CAND_BYTES = 4,
  localparam int CAND_BITS = 8 * CAND_BYTES
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  md5Strobe_t           strobe,
  input  logic [CAND_BITS-1:0] cand,
  input  logic                 targetWe,
  input  logic [1:0]           targetIdx,
  input  logic [31:0]          targetData,
  output logic                 digestValid,
  output logic [127:0]         digestOut,
  output logic [CAND_BITS-1:0] digestCand,
  output logic                 hit
);
  md5State_t            stState [0:NUM_STEPS];
  logic                 stValid [0:NUM_STEPS];
  logic [CAND_BITS-1:0] stCand  [0:NUM_STEPS];
  logic [127:0]         targetQ;
  logic [127:0]         finalSum;

  assign stState[0] = '{a: IV_A, b: IV_B, c: IV_C, d: IV_D};
  assign stValid[0] = strobe.inject;
  assign stCand[0]  = cand;

  for (genvar k = 0; k < NUM_STEPS; k++) begin : gStep
    md5Step #(.STEP(k), .CAND_BYTES(CAND_BYTES)) uStep (
      .clk(clk), .rstN(rstN), .flush(strobe.flush),
      .inValid(stValid[k]), .inState(stState[k]), .inCand(stCand[k]),
      .outValid(stValid[k+1]), .outState(stState[k+1]), .outCand(stCand[k+1])
    );
  end

  assign finalSum = {stState[NUM_STEPS].d + IV_D, stState[NUM_STEPS].c + IV_C,
                     stState[NUM_STEPS].b + IV_B, stState[NUM_STEPS].a + IV_A};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      targetQ     <= '0;
      digestValid <= 1'b0;
      hit         <= 1'b0;
    end else begin
      if (targetWe) targetQ[{targetIdx, 5'b0} +: 32] <= targetData;
      digestValid <= stValid[NUM_STEPS] & ~strobe.flush;
      hit         <= stValid[NUM_STEPS] & ~strobe.flush & (finalSum == targetQ);
    end
  end

  always_ff @(posedge clk) begin
    digestOut  <= finalSum;
    digestCand <= stCand[NUM_STEPS];
  end
endmodule

// File: rtl/md5SearchCtrl.sv
module md5SearchCtrl
  import md5SearchPkg::*;
#(
  parameter int CAND_BYTES = 4,
  localparam int CAND_BITS = 8 * CAND_BYTES
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic                 stop,
  input  logic [CAND_BITS-1:0] startValue,
  input  logic                 hit,
  input  logic [CAND_BITS-1:0] digestCand,
  output md5Strobe_t           strobe,
  output logic [CAND_BITS-1:0] cand,
  output logic                 found,
  output logic [CAND_BITS-1:0] foundCandidate
);
  logic                 running;
  logic [CAND_BITS-1:0] cntQ;

  assign strobe.flush  = start;
  assign strobe.inject = running;
  assign cand          = cntQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running        <= 1'b0;
      cntQ           <= '0;
      found          <= 1'b0;
      foundCandidate <= '0;
    end else if (start) begin
      running <= 1'b1;
      cntQ    <= startValue;
      found   <= 1'b0;
    end else begin
      if (stop)         running <= 1'b0;
      else if (running) cntQ    <= cntQ + 1'b1;
      if (hit && !found) begin
        found          <= 1'b1;
        foundCandidate <= digestCand;
      end
    end
  end
endmodule

// File: rtl/md5SearchCore.sv
module md5SearchCore
  import md5SearchPkg::*;
#(
  parameter int CAND_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic                    stop,
  input  logic [8*CAND_BYTES-1:0] startValue,
  input  logic                    targetWe,
  input  logic [1:0]              targetIdx,
  input  logic [31:0]             targetData,
  output logic                    digestValid,
  output logic [127:0]            digestOut,
  output logic [8*CAND_BYTES-1:0] digestCand,
  output logic                    found,
  output logic [8*CAND_BYTES-1:0] foundCandidate
);
  localparam int CAND_BITS = 8 * CAND_BYTES;

  md5Strobe_t           strobe;
  logic [CAND_BITS-1:0] cand;
  logic                 hit;

  md5SearchCtrl #(.CAND_BYTES(CAND_BYTES)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .stop(stop), .startValue(startValue),
    .hit(hit), .digestCand(digestCand), .strobe(strobe), .cand(cand),
    .found(found), .foundCandidate(foundCandidate)
  );

  md5Datapath #(.CAND_BYTES(CAND_BYTES)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cand(cand),
    .targetWe(targetWe), .targetIdx(targetIdx), .targetData(targetData),
    .digestValid(digestValid), .digestOut(digestOut), .digestCand(digestCand), .hit(hit)
  );
endmodule

// File: rtl/md5SearchChecker.sv
module md5SearchChecker #(
  parameter int CAND_BITS = 32
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 start,
  input logic                 digestValid,
  input logic [CAND_BITS-1:0] digestCand,
  input logic                 found,
  input logic [CAND_BITS-1:0] foundCandidate
);
  assert_flush_on_start_R7: assert property (@(posedge clk) disable iff (!rstN)
    start |=> !digestValid);

  assert_found_cleared_R7: assert property (@(posedge clk) disable iff (!rstN)
    start |=> !found);

  assert_found_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (found && !start) |=> found);

  assert_found_follows_digest_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(found) |-> $past(digestValid));

  assert_cand_held_R6: assert property (@(posedge clk) disable iff (!rstN)
    (found && $past(found) && !$past(start)) |-> $stable(foundCandidate));

  assert_stream_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (digestValid && $past(digestValid)) |-> (digestCand == CAND_BITS'($past(digestCand) + 1'b1)));
endmodule

bind md5SearchCore md5SearchChecker #(.CAND_BITS(8 * CAND_BYTES)) uChk (
  .clk(clk), .rstN(rstN), .start(start), .digestValid(digestValid),
  .digestCand(digestCand), .found(found), .foundCandidate(foundCandidate)
);

// File: tb/tb_md5SearchCore.sv
`timescale 1ns/1ps
module tb_md5SearchCore;
  localparam int CB = 3;
  localparam int CW = 8 * CB;
  localparam logic [CW-1:0] ABC = 24'h636261;
  localparam logic [127:0] ABC_DIGEST = 128'h727fe1287d3f96d6b04fd23c98500190;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, stop = 1'b0, targetWe = 1'b0;
  logic [CW-1:0] startValue = '0;
  logic [1:0] targetIdx = '0;
  logic [31:0] targetData = '0;
  logic digestValid, found;
  logic [127:0] digestOut;
  logic [CW-1:0] digestCand, foundCandidate;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  md5SearchCore #(.CAND_BYTES(CB)) dut (
    .clk(clk), .rstN(rstN), .start(start), .stop(stop), .startValue(startValue),
    .targetWe(targetWe), .targetIdx(targetIdx), .targetData(targetData),
    .digestValid(digestValid), .digestOut(digestOut), .digestCand(digestCand),
    .found(found), .foundCandidate(foundCandidate)
  );

  // Reference hash, written from the algorithm definition
  logic [31:0] kTab [64];
  int sTab [4][4] = '{'{7, 12, 17, 22}, '{5, 9, 14, 20}, '{4, 11, 16, 23}, '{6, 10, 15, 21}};

  initial begin
    for (int i = 0; i < 64; i++) begin
      real v;
      longint q;
      v = $sin(real'(i + 1));
      if (v < 0.0) v = -v;
      v = v * 4294967296.0;
      q = longint'(v);
      if (real'(q) > v) q = q - 1;
      kTab[i] = q[31:0];
    end
  end

  function automatic logic [127:0] refDigest(input logic [CW-1:0] c);
    logic [7:0] by [64];
    logic [31:0] w [16];
    logic [31:0] a, b, cc, d, f, t;
    int g;
    // R1: candidate bytes little-endian, 0x80 pad, bit length in word 14
    for (int n = 0; n < 64; n++)
      by[n] = (n < CB) ? c[8*n +: 8] : ((n == CB) ? 8'h80 : 8'h00);
    for (int j = 0; j < 16; j++) w[j] = {by[4*j+3], by[4*j+2], by[4*j+1], by[4*j]};
    w[14] = 32'(CB * 8);
    w[15] = 32'h0;
    a = 32'h67452301; b = 32'hefcdab89; cc = 32'h98badcfe; d = 32'h10325476;
    for (int i = 0; i < 64; i++) begin
      if (i < 16)      begin f = (b & cc) | (~b & d);  g = i; end
      else if (i < 32) begin f = (d & b) | (~d & cc);  g = (5 * i + 1) % 16; end
      else if (i < 48) begin f = b ^ cc ^ d;           g = (3 * i + 5) % 16; end
      else             begin f = cc ^ (b | ~d);        g = (7 * i) % 16; end
      t = a + f + kTab[i] + w[g];
      a = d; d = cc; cc = b;
      b = b + ((t << sTab[i/16][i%4]) | (t >> (32 - sTab[i/16][i%4])));
    end
    return {d + 32'h10325476, cc + 32'h98badcfe, b + 32'hefcdab89, a + 32'h67452301};
  endfunction

  // Cycle model: queue of 65 slots (64 steps + output register)
  bit            mv [0:64];
  logic [CW-1:0] mc [0:64];
  bit            mRun = 0;
  logic [CW-1:0] mCnt = '0;
  bit            mFound = 0;
  logic [CW-1:0] mFoundCand = '0;
  logic [127:0]  mTarget = '0;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k <= 64; k++) begin mv[k] = 0; mc[k] = '0; end
      mRun = 0; mCnt = '0; mFound = 0; mFoundCand = '0; mTarget = '0;
    end else begin
      if (start) mFound = 0;
      else if (mv[64] && !mFound && refDigest(mc[64]) == mTarget) begin
        mFound = 1; mFoundCand = mc[64];
      end
      for (int k = 64; k >= 1; k--) begin mv[k] = start ? 0 : mv[k-1]; mc[k] = mc[k-1]; end
      mv[0] = start ? 0 : mRun;
      mc[0] = mCnt;
      if (start) begin mRun = 1; mCnt = startValue; end
      else if (stop) mRun = 0;
      else if (mRun) mCnt = mCnt + 1'b1;
      if (targetWe) mTarget[32*targetIdx +: 32] = targetData;
    end
  end

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      check(digestValid == mv[64], "R4/R7/R8 digestValid", 128'(digestValid), 128'(mv[64]));
      if (mv[64]) begin
        check(digestCand == mc[64], "R3 digestCand", 128'(digestCand), 128'(mc[64]));
        check(digestOut == refDigest(mc[64]), "R1/R2 digestOut", digestOut, refDigest(mc[64]));
      end
      check(found == mFound, "R6 found", 128'(found), 128'(mFound));
      if (mFound) check(foundCandidate == mFoundCand, "R6 foundCandidate",
                        128'(foundCandidate), 128'(mFoundCand));
    end
  end

  task automatic writeTarget(input logic [127:0] t);
    for (int i = 0; i < 4; i++) begin
      targetWe = 1'b1; targetIdx = 2'(i); targetData = t[32*i +: 32];
      @(negedge clk);
    end
    targetWe = 1'b0;
  endtask

  task automatic pulseStart(input logic [CW-1:0] v);
    start = 1'b1; startValue = v;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finishRun;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int lat;
    bit sawAbc, sawWrap;
    logic [CW-1:0] prevCand;
    bit prevValid;
    repeat (3) @(negedge clk);
    check(digestValid == 1'b0, "R9 digestValid in reset", 128'(digestValid), 128'(0));
    check(found == 1'b0, "R9 found in reset", 128'(found), 128'(0));
    rstN = 1'b1;
    @(negedge clk);
    check(digestValid == 1'b0 && found == 1'b0, "R9 idle after reset", 128'({digestValid, found}), 128'(0));

    check(refDigest(ABC) == ABC_DIGEST, "R2 model known vector", refDigest(ABC), ABC_DIGEST);
    writeTarget(ABC_DIGEST);   // R5 word order: word i into bits 32i

    pulseStart(ABC - 24'd20);
    lat = 0;
    while (!digestValid && lat < 200) begin @(negedge clk); lat++; end
    check(lat == 65, "R4 fill latency", 128'(lat), 128'(65));
    sawAbc = 0;
    for (int i = 0; i < 40; i++) begin
      if (digestValid && digestCand == ABC) begin
        sawAbc = 1;
        check(digestOut == ABC_DIGEST, "R2 abc digest", digestOut, ABC_DIGEST);
        check(found == 1'b0, "R6 found not yet", 128'(found), 128'(0));
        @(negedge clk);
        check(found == 1'b1, "R6 found one cycle later", 128'(found), 128'(1));
      end else @(negedge clk);
    end
    check(sawAbc, "R2 abc candidate seen", 128'(sawAbc), 128'(1));
    check(found && foundCandidate == ABC, "R5/R6 match reported", 128'(foundCandidate), 128'(ABC));

    stop = 1'b1; @(negedge clk); stop = 1'b0;
    repeat (70) @(negedge clk);
    check(digestValid == 1'b0, "R8 drained after stop", 128'(digestValid), 128'(0));
    check(found == 1'b1, "R6 found sticky", 128'(found), 128'(1));

    pulseStart(24'hFFFFF0);
    check(found == 1'b0, "R7 found cleared", 128'(found), 128'(0));
    sawWrap = 0; prevValid = 0; prevCand = '0;
    for (int i = 0; i < 100; i++) begin
      if (digestValid && prevValid && prevCand == 24'hFFFFFF && digestCand == 24'h0) sawWrap = 1;
      prevValid = digestValid; prevCand = digestCand;
      @(negedge clk);
    end
    check(sawWrap, "R3 counter wrap", 128'(sawWrap), 128'(1));

    writeTarget(refDigest(24'h000105));
    repeat (20) @(negedge clk);
    pulseStart(24'h000100);   // restart with digests in flight
    check(digestValid == 1'b0, "R7 flush on restart", 128'(digestValid), 128'(0));
    repeat (100) @(negedge clk);
    check(found && foundCandidate == 24'h000105, "R5/R6 second target", 128'(foundCandidate), 128'(24'h000105));

    stop = 1'b1; start = 1'b1; startValue = 24'h000200;
    @(negedge clk);
    stop = 1'b0; start = 1'b0;
    repeat (70) @(negedge clk);
    check(digestValid == 1'b1, "R7 start overrides stop", 128'(digestValid), 128'(1));
    finishRun();
  end
endmodule